// File: doc/BRIEF.md
# SIMD Warp Issue Scheduler

The scheduler keeps track of a set of resident warps. A warp is a group of threads that all run the same instruction. The scheduler issues one warp instruction at a time onto a narrower row of processing lanes. A warp of `WARP_SIZE` threads is spread over `NUM_LANES` lanes in `WARP_SIZE/NUM_LANES` back-to-back beats. With the default sizes, 32 threads go over 8 lanes in 4 beats, chosen from 24 resident warps.

The scheduler switches warps only at instruction boundaries. It picks the next warp by round-robin among the warps whose ready flag is set. This lets a waiting warp be skipped while the others keep the lanes busy. Each beat names:

- the warp,
- the beat index,
- the thread ID carried on each lane,
- a per-lane enable taken from that warp's active-thread mask.

A thread switched off by divergence still takes its lane slot, so the beat is issued even when every enable in it is low.

The issue side is a valid/ready stream. A beat is accepted on a cycle where `issue_valid` and `issue_ready` are both high. While `issue_valid` is high and `issue_ready` is low, the beat on the outputs stays unchanged. `issue_valid` never drops in the middle of an instruction. The ready flags and thread masks are plain control inputs, sampled only when a new warp is chosen.

Top module: `warp_issue_sched`

## Requirements
- R1: During and directly after reset, `issue_valid` is low and every bit of `issue_lane_en` is low.
- R2: A warp, once chosen, is issued for exactly `WARP_SIZE/NUM_LANES` accepted beats with `issue_sub` counting 0, 1, 2, 3. The next warp is chosen only on the cycle the last beat is accepted, or while idle.
- R3: The warp choice is round-robin. The search starts at the warp after the last one issued, wraps past the highest index, and takes the first warp whose ready bit is set. After reset the search starts at warp 0.
- R4: In beat k, lane i carries thread ID `k*NUM_LANES + i`. The thread IDs are packed into `issue_tid`, with lane i at bits `[i*5 +: 5]`.
- R5: Lane i is enabled in beat k exactly when bit `k*NUM_LANES + i` of the chosen warp's mask is set. The mask is the one at bits `[w*WARP_SIZE +: WARP_SIZE]` of `warp_mask`, sampled in the cycle warp w is chosen. A beat whose enables are all low is still issued and still takes its cycle.
- R6: When no warp is ready at a choice point, `issue_valid` is low on the next cycle. When it is low, every enable is low. When idle and any warp is ready, `issue_valid` is high on the next cycle.
- R7: While `issue_valid` is high and `issue_ready` is low, every issue output holds its value into the next cycle.
- R8: Changes to ready flags or masks in the middle of an instruction do not alter or abort it.
- R9: `issue_last` is high exactly on the final beat of a warp instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| warp_ready | input | NUM_WARPS | Per-warp ready flag, bit w for warp w |
| warp_mask | input | NUM_WARPS*WARP_SIZE | Per-warp active-thread masks, warp w at `[w*WARP_SIZE +: WARP_SIZE]` |
| issue_ready | input | 1 | Downstream accepts the current beat |
| issue_valid | output | 1 | A beat is on the issue outputs |
| issue_warp | output | 5 | Warp being issued |
| issue_sub | output | 2 | Beat index within the warp instruction |
| issue_last | output | 1 | Final beat of the instruction |
| issue_tid | output | NUM_LANES*5 | Thread ID per lane, lane i at `[i*5 +: 5]` |
| issue_lane_en | output | NUM_LANES | Per-lane enable |

## Verification
The assertions assume that `issue_ready` is a clean level that may change on any cycle. They also assume that ready flags and masks change only between clock edges. The checks for the choice of warp compare the issued warp against the ready vector from the cycle before.

The stimulus drives every input half a cycle away from the sampling edge. It drives ready flags and masks with arbitrary values on every cycle, including in the middle of an instruction, and stalls `issue_ready` at random. This keeps all of the assumptions while still covering mid-instruction changes and stalls.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
  localparam int DEF_WARPS     = 24;
  localparam int DEF_WARP_SIZE = 32;
  localparam int DEF_LANES     = 8;

  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
  parameter int N     = 24,
  parameter int IDX_W = 5
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] prev_idx,
  output logic             pick_valid,
  output logic [IDX_W-1:0] pick_idx
);
  int cand;

  always_comb begin
    pick_valid = 1'b0;
    pick_idx   = '0;
    cand       = 0;
    for (int off = 1; off <= N; off++) begin
      cand = (int'(prev_idx) + off) % N;
      if (!pick_valid && req[cand]) begin
        pick_valid = 1'b1;
        pick_idx   = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/warp_lane_map.sv
module warp_lane_map #(
  parameter int WARP_SIZE = 32,
  parameter int NUM_LANES = 8,
  parameter int SUB_W     = 2,
  parameter int TID_W     = 5
) (
  input  logic                       beat_valid,
  input  logic [SUB_W-1:0]           beat_idx,
  input  logic [WARP_SIZE-1:0]       thread_mask,
  output logic [NUM_LANES*TID_W-1:0] lane_tid,
  output logic [NUM_LANES-1:0]       lane_en
);
  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    logic [TID_W-1:0] tid;
    assign tid = TID_W'(int'(beat_idx) * NUM_LANES + i);
    assign lane_tid[i*TID_W +: TID_W] = tid;
    assign lane_en[i] = beat_valid & thread_mask[tid];
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS = DEF_WARPS,
  parameter int WARP_SIZE = DEF_WARP_SIZE,
  parameter int NUM_LANES = DEF_LANES,
  localparam int NUM_SUB  = WARP_SIZE / NUM_LANES,
  localparam int WID_W    = bits_for(NUM_WARPS),
  localparam int SUB_W    = bits_for(NUM_SUB),
  localparam int TID_W    = bits_for(WARP_SIZE)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_WARPS-1:0]           warp_ready,
  input  logic [NUM_WARPS*WARP_SIZE-1:0] warp_mask,
  input  logic                           issue_ready,
  output logic                           issue_valid,
  output logic [WID_W-1:0]               issue_warp,
  output logic [SUB_W-1:0]               issue_sub,
  output logic                           issue_last,
  output logic [NUM_LANES*TID_W-1:0]     issue_tid,
  output logic [NUM_LANES-1:0]           issue_lane_en
);
  logic                 busy_q;
  logic [WID_W-1:0]     warp_q;
  logic [SUB_W-1:0]     sub_q;
  logic [WARP_SIZE-1:0] mask_q;

  logic                 fire;
  logic                 at_last;
  logic                 boundary;
  logic                 pick_valid;
  logic [WID_W-1:0]     pick_idx;
  logic [WARP_SIZE-1:0] pick_mask;

  assign fire     = busy_q & issue_ready;
  assign at_last  = (sub_q == SUB_W'(NUM_SUB - 1));
  assign boundary = ~busy_q | (fire & at_last);

  warp_rr_pick #(.N(NUM_WARPS), .IDX_W(WID_W)) u_pick (
    .req        (warp_ready),
    .prev_idx   (warp_q),
    .pick_valid (pick_valid),
    .pick_idx   (pick_idx)
  );

  assign pick_mask = warp_mask[int'(pick_idx) * WARP_SIZE +: WARP_SIZE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      warp_q <= WID_W'(NUM_WARPS - 1);
      sub_q  <= '0;
      mask_q <= '0;
    end else if (boundary) begin
      busy_q <= pick_valid;
      if (pick_valid) begin
        warp_q <= pick_idx;
        sub_q  <= '0;
        mask_q <= pick_mask;
      end
    end else if (fire) begin
      sub_q <= sub_q + SUB_W'(1);
    end
  end

  warp_lane_map #(
    .WARP_SIZE (WARP_SIZE),
    .NUM_LANES (NUM_LANES),
    .SUB_W     (SUB_W),
    .TID_W     (TID_W)
  ) u_lanes (
    .beat_valid  (busy_q),
    .beat_idx    (sub_q),
    .thread_mask (mask_q),
    .lane_tid    (issue_tid),
    .lane_en     (issue_lane_en)
  );

  assign issue_valid = busy_q;
  assign issue_warp  = warp_q;
  assign issue_sub   = sub_q;
  assign issue_last  = busy_q & at_last;
endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS = 24,
  parameter int WARP_SIZE = 32,
  parameter int NUM_LANES = 8,
  parameter int WID_W     = 5,
  parameter int SUB_W     = 2,
  parameter int TID_W     = 5
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_WARPS-1:0]           warp_ready,
  input logic                           issue_ready,
  input logic                           issue_valid,
  input logic [WID_W-1:0]               issue_warp,
  input logic [SUB_W-1:0]               issue_sub,
  input logic                           issue_last,
  input logic [NUM_LANES*TID_W-1:0]     issue_tid,
  input logic [NUM_LANES-1:0]           issue_lane_en
);
  logic at_boundary;
  assign at_boundary = !issue_valid || (issue_ready && issue_last);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (issue_lane_en == '0));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=>
      (issue_valid && $stable(issue_warp) && $stable(issue_sub) &&
       $stable(issue_tid) && $stable(issue_lane_en)));

  p_beat_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready && !issue_last) |=>
      (issue_valid && $stable(issue_warp) &&
       (issue_sub == $past(issue_sub) + SUB_W'(1))));

  p_start_beat_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_valid) |-> (issue_sub == '0));

  p_pick_was_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    at_boundary |=> (!issue_valid ||
      ((issue_sub == '0) && ((($past(warp_ready) >> issue_warp) & 1) != 0))));

  p_no_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && (warp_ready == '0)) |=> !issue_valid);

  p_ready_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_valid && (warp_ready != '0)) |=> issue_valid);

  p_last_final_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue_last |-> (issue_valid && (issue_sub == SUB_W'(WARP_SIZE / NUM_LANES - 1))));
endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS (NUM_WARPS),
  .WARP_SIZE (WARP_SIZE),
  .NUM_LANES (NUM_LANES),
  .WID_W     (WID_W),
  .SUB_W     (SUB_W),
  .TID_W     (TID_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .warp_ready    (warp_ready),
  .issue_ready   (issue_ready),
  .issue_valid   (issue_valid),
  .issue_warp    (issue_warp),
  .issue_sub     (issue_sub),
  .issue_last    (issue_last),
  .issue_tid     (issue_tid),
  .issue_lane_en (issue_lane_en)
);

// File: tb/warp_issue_sched_bench.sv
module warp_issue_sched_bench;
  localparam int NW = 24;
  localparam int WS = 32;
  localparam int NL = 8;
  localparam int NS = WS / NL;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NW-1:0]   warp_ready = '0;
  logic [NW*WS-1:0] warp_mask = '0;
  logic            issue_ready = 1'b1;
  logic            issue_valid;
  logic [4:0]      issue_warp;
  logic [1:0]      issue_sub;
  logic            issue_last;
  logic [NL*5-1:0] issue_tid;
  logic [NL-1:0]   issue_lane_en;

  always #4 clk = ~clk;

  warp_issue_sched u_warp_issue_sched (
    .clk           (clk),
    .rst_n         (rst_n),
    .warp_ready    (warp_ready),
    .warp_mask     (warp_mask),
    .issue_ready   (issue_ready),
    .issue_valid   (issue_valid),
    .issue_warp    (issue_warp),
    .issue_sub     (issue_sub),
    .issue_last    (issue_last),
    .issue_tid     (issue_tid),
    .issue_lane_en (issue_lane_en)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference state, derived from the requirements
  bit        m_busy;
  int        m_warp;
  int        m_sub;
  bit [WS-1:0] m_mask;

  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_busy = 0; m_warp = NW - 1; m_sub = 0; m_mask = '0;
  endtask

  task automatic model_step();
    bit fire;
    bit found;
    fire = m_busy && issue_ready;
    if (!m_busy || (fire && m_sub == NS - 1)) begin
      found = 0;
      for (int off = 1; off <= NW; off++) begin
        int c;
        c = (m_warp + off) % NW;
        if (!found && warp_ready[c]) begin
          found = 1; m_warp = c; m_sub = 0;
          m_mask = warp_mask[c*WS +: WS];
        end
      end
      m_busy = found;
    end else if (fire) begin
      m_sub++;
    end
  endtask

  task automatic compare();
    check(issue_valid == m_busy, "R6 valid", issue_valid, m_busy);
    if (m_busy) begin
      check(issue_warp == m_warp, "R3 warp", issue_warp, m_warp);
      check(issue_sub == m_sub, "R2 beat", issue_sub, m_sub);
      check(issue_last == (m_sub == NS - 1), "R9 last", issue_last, m_sub == NS - 1);
      for (int i = 0; i < NL; i++) begin
        check(issue_tid[i*5 +: 5] == m_sub*NL + i, "R4 tid",
              issue_tid[i*5 +: 5], m_sub*NL + i);
        check(issue_lane_en[i] == m_mask[m_sub*NL + i], "R5 enable",
              issue_lane_en[i], m_mask[m_sub*NL + i]);
      end
    end else begin
      check(issue_lane_en == '0, "R6 idle enables", issue_lane_en, 0);
    end
  endtask

  // one clock: model sees the same inputs as the design, check after the edge
  task automatic tick();
    @(posedge clk);
    model_step();
    #2;
    compare();
  endtask

  function automatic logic [NW*WS-1:0] rand_masks();
    logic [NW*WS-1:0] v;
    for (int w = 0; w < NW; w++) v[w*WS +: WS] = $urandom;
    return v;
  endfunction

  initial begin : watchdog
    wait (cycles > 150000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seen_wrap;
    model_reset();
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(issue_valid == 1'b0, "R1 valid in reset", issue_valid, 0);
    check(issue_lane_en == '0, "R1 enables in reset", issue_lane_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    warp_ready = '0;
    tick();
    check(issue_valid == 1'b0, "R1 valid after reset", issue_valid, 0);

    // full occupancy, full masks: R2 R3 R4
    @(negedge clk);
    warp_ready = '1;
    warp_mask = '1;
    repeat (NW * NS + 8) tick();

    // divergent masks, including an all-off warp: R5
    @(negedge clk);
    warp_mask = rand_masks();
    warp_mask[5*WS +: WS] = '0;
    warp_mask[6*WS +: WS] = 32'h0000_00ff;
    repeat (NW * NS * 2) tick();

    // ready flags and masks churning every cycle: R8 R3
    for (int n = 0; n < 600; n++) begin
      @(negedge clk);
      warp_ready = NW'($urandom) & NW'($urandom);
      warp_mask = rand_masks();
      tick();
    end

    // nobody ready: R6
    @(negedge clk);
    warp_ready = '0;
    repeat (12) tick();
    check(issue_valid == 1'b0, "R6 idle with nothing ready", issue_valid, 0);

    // wrap-around: only highest, then only lowest: R3
    @(negedge clk);
    warp_ready = '0;
    warp_ready[NW-1] = 1'b1;
    repeat (NS) tick();
    @(negedge clk);
    warp_ready = '0;
    warp_ready[0] = 1'b1;
    warp_ready[NW-1] = 1'b1;
    seen_wrap = 0;
    repeat (NS * 3) begin
      tick();
      if (issue_valid && issue_warp == 0) seen_wrap = 1;
    end
    check(seen_wrap == 1, "R3 wrap to warp 0", seen_wrap, 1);

    // back-pressure with churn: R7
    for (int n = 0; n < 800; n++) begin
      @(negedge clk);
      issue_ready = ($urandom % 3) != 0;
      warp_ready = NW'($urandom);
      warp_mask = rand_masks();
      tick();
    end

    // long stall in the middle of an instruction: R7
    @(negedge clk);
    issue_ready = 1'b1;
    warp_ready = '1;
    tick();
    @(negedge clk);
    issue_ready = 1'b0;
    repeat (10) tick();
    @(negedge clk);
    issue_ready = 1'b1;
    repeat (20) tick();

    // reset in the middle of traffic: R1
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #2;
    model_reset();
    check(issue_valid == 1'b0, "R1 valid after mid-run reset", issue_valid, 0);
    check(issue_lane_en == '0, "R1 enables after mid-run reset", issue_lane_en, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (NS * 2) tick();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule